// File: doc/BRIEF.md
# Grouped Write/Read Slot Scheduler

This block shares one single-port buffer memory data bus between two request queues. Incoming segments arrive as write requests and outgoing segments as read requests. The bus is divided into slots on a fixed, repeating schedule: four write slots in a row, then a programmable turnaround gap, then four read slots in a row, then the same gap again. Each slot carries one independent access, and its address is not tied to the addresses used by other slots in the same group.

Write and read slots come in equal numbers, so each direction gets exactly half of the data slots. The bus pays the direction-change penalty only twice per period, which spreads the penalty over four accesses. A slot whose queue is empty is still spent, as an idle cycle, so the schedule never slips. Four counters record issued writes, issued reads, idle data slots and turnaround cycles, so the achieved efficiency can be read from the outputs.

Top module: `wr_rd_slot_sched`

## Requirements
- R1: While reset is held, and after it is released until the first clock edge, mem_cmd_valid is 0, all four counters read 0, wr_ready is 1 and rd_ready is 0. The schedule always starts with the first write slot.
- R2: Data slots follow a fixed pattern of exactly four write slots, then exactly four read slots, repeated with no end.
- R3: At each direction change (after the last write slot and after the last read slot), exactly T cycles are inserted in which neither ready is high, where T is the value of ta_cycles (0 to 3). No gap is inserted between two slots of the same direction.
- R4: wr_ready is high only in write slots and rd_ready only in read slots. The two are never high together.
- R5: A request accepted in a slot (valid and ready both high) appears on the command port in the next cycle: mem_cmd_valid=1, mem_cmd_write=1 for a write or 0 for a read, and mem_cmd_addr set to the request address. mem_cmd_data carries the write data for a write and is all zeros for a read.
- R6: A data slot whose queue has no valid request gives mem_cmd_valid=0 in the next cycle and does not shift the pattern.
- R7: cnt_writes, cnt_reads, cnt_idle_slots and cnt_turnaround go up by one for each issued write, each issued read, each unused data slot and each gap cycle. Each counter updates at the same edge as the command.
- R8: ta_cycles is sampled in the last slot of a group. A change to ta_cycles during a gap does not change the length of that gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ta_cycles | input | 2 | Gap length in cycles at each direction change |
| wr_valid | input | 1 | Write request pending |
| wr_ready | output | 1 | High during a write slot |
| wr_addr | input | 16 | Write address |
| wr_data | input | 512 | Write data word |
| rd_valid | input | 1 | Read request pending |
| rd_ready | output | 1 | High during a read slot |
| rd_addr | input | 16 | Read address |
| mem_cmd_valid | output | 1 | Command issued this cycle |
| mem_cmd_write | output | 1 | 1 = write, 0 = read |
| mem_cmd_addr | output | 16 | Command address |
| mem_cmd_data | output | 512 | Write data, zero for reads |
| cnt_writes | output | 16 | Issued write count |
| cnt_reads | output | 16 | Issued read count |
| cnt_idle_slots | output | 16 | Unused data slot count |
| cnt_turnaround | output | 16 | Gap cycle count |

## Verification
The bench checks the handshake and the command port in every cycle, over periods that mix every gap length with full, empty and sparse queues. A design that let an empty slot shift the pattern would raise a ready in the wrong cycle. A design that put a gap between two same-direction slots, or took a gap length off by one, would also raise a ready in the wrong cycle. The bench checks the zero-gap handoff, where a design that still inserted a cycle would show the read ready late. It also changes ta_cycles inside a gap; a design that re-read the setting there would cut that gap short. A reset in the middle of a read group must return the block to the first write slot with all counters cleared, and the counters are compared against tallies kept by the bench after every period.

// File: rtl/wrs_pkg.sv
// Package: shared types for the grouped write/read slot scheduler.
// Assumes: nothing beyond the standard types.
package wrs_pkg;
    typedef enum logic [1:0] {
        PH_WR     = 2'd0,
        PH_GAP_WR = 2'd1,   // gap after the write group
        PH_RD     = 2'd2,
        PH_GAP_RD = 2'd3    // gap after the read group
    } phase_e;
endpackage

// File: rtl/wrs_slot_seq.sv
// Module: slot sequencer. It steps through GROUP_LEN write slots, a gap,
// GROUP_LEN read slots and a gap, and repeats. Each slot is spent whether
// or not it is used.
// Assumes: ta_cycles is meaningful only in the last slot of a group.
module wrs_slot_seq
    import wrs_pkg::*;
#(
    parameter int GROUP_LEN = 4,
    parameter int TA_W      = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TA_W-1:0] ta_cycles,
    output logic            wr_slot,
    output logic            rd_slot,
    output logic            gap_slot
);
    localparam int IDX_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_LEN - 1);

    phase_e          phase;
    logic [IDX_W-1:0] slot_idx;
    logic [TA_W-1:0]  gap_left;
    logic             group_end;

    // Decode the kind of the current cycle from the phase.
    always_comb begin
        wr_slot   = (phase == PH_WR);
        rd_slot   = (phase == PH_RD);
        gap_slot  = (phase == PH_GAP_WR) || (phase == PH_GAP_RD);
        group_end = (wr_slot || rd_slot) && (slot_idx == LAST_IDX);
    end

    // Advance the phase, the slot index and the gap countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_WR;
            slot_idx <= '0;
            gap_left <= '0;
        end else begin
            case (phase)
                PH_WR: begin
                    if (group_end) begin
                        slot_idx <= '0;
                        if (ta_cycles == '0) begin
                            phase <= PH_RD;
                        end else begin
                            phase    <= PH_GAP_WR;
                            gap_left <= ta_cycles - TA_W'(1);
                        end
                    end else begin
                        slot_idx <= slot_idx + IDX_W'(1);
                    end
                end
                PH_RD: begin
                    if (group_end) begin
                        slot_idx <= '0;
                        if (ta_cycles == '0) begin
                            phase <= PH_WR;
                        end else begin
                            phase    <= PH_GAP_RD;
                            gap_left <= ta_cycles - TA_W'(1);
                        end
                    end else begin
                        slot_idx <= slot_idx + IDX_W'(1);
                    end
                end
                PH_GAP_WR: begin
                    if (gap_left == '0) phase <= PH_RD;
                    else                gap_left <= gap_left - TA_W'(1);
                end
                default: begin
                    if (gap_left == '0) phase <= PH_WR;
                    else                gap_left <= gap_left - TA_W'(1);
                end
            endcase
        end
    end

    AST_GROUP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot && group_end) |=> !wr_slot); // R2
    AST_ZERO_GAP_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_slot && group_end && ta_cycles == '0) |=> rd_slot); // R3
    AST_GAP_LEADS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_slot && $past(rd_slot)) |-> (phase == PH_GAP_RD)); // R3
endmodule

// File: rtl/wrs_cmd_reg.sv
// Module: command register. It captures the accepted request of the current
// slot and presents it on the memory command port one cycle later.
// Assumes: at most one of wr_fire and rd_fire is high in any cycle.
module wrs_cmd_reg #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              rd_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              cmd_valid,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);
    // Register the command chosen by whichever side fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_write <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= wr_fire || rd_fire;
            cmd_write <= wr_fire;
            cmd_addr  <= wr_fire ? wr_addr : (rd_fire ? rd_addr : '0);
            cmd_data  <= wr_fire ? wr_data : '0;
        end
    end
endmodule

// File: rtl/wrs_counters.sv
// Module: efficiency counters for issued writes, issued reads, unused data
// slots and gap cycles. Each counter wraps at 2**CNT_W.
// Assumes: a data slot is one in which wr_slot or rd_slot is high.
module wrs_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_fire,
    input  logic             rd_fire,
    input  logic             data_slot,
    input  logic             gap_slot,
    output logic [CNT_W-1:0] cnt_writes,
    output logic [CNT_W-1:0] cnt_reads,
    output logic [CNT_W-1:0] cnt_idle,
    output logic [CNT_W-1:0] cnt_gap
);
    logic [CNT_W-1:0] slot_sum;

    // Add up the counters that together cover every data slot.
    always_comb slot_sum = cnt_writes + cnt_reads + cnt_idle;

    // Bump each counter by the event of this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_writes <= '0;
            cnt_reads  <= '0;
            cnt_idle   <= '0;
            cnt_gap    <= '0;
        end else begin
            cnt_writes <= cnt_writes + CNT_W'(wr_fire);
            cnt_reads  <= cnt_reads  + CNT_W'(rd_fire);
            cnt_idle   <= cnt_idle   + CNT_W'(data_slot && !wr_fire && !rd_fire);
            cnt_gap    <= cnt_gap    + CNT_W'(gap_slot);
        end
    end

    AST_SLOT_SUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_slot |=> (slot_sum == $past(slot_sum) + CNT_W'(1))); // R7
    AST_GAP_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        gap_slot |=> $stable(slot_sum)); // R7
endmodule

// File: rtl/wr_rd_slot_sched.sv
// Module: grouped write/read slot scheduler (top). It shares one memory bus
// between a write queue and a read queue on a fixed schedule of four write
// slots, a gap, four read slots and a gap.
// Assumes: the request queues keep valid and the payload stable until ready.
module wr_rd_slot_sched #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 512,
    parameter int CNT_W     = 16,
    parameter int TA_W      = 2,
    parameter int GROUP_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TA_W-1:0]   ta_cycles,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    output logic              rd_ready,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              mem_cmd_valid,
    output logic              mem_cmd_write,
    output logic [ADDR_W-1:0] mem_cmd_addr,
    output logic [DATA_W-1:0] mem_cmd_data,
    output logic [CNT_W-1:0]  cnt_writes,
    output logic [CNT_W-1:0]  cnt_reads,
    output logic [CNT_W-1:0]  cnt_idle_slots,
    output logic [CNT_W-1:0]  cnt_turnaround
);
    logic wr_slot, rd_slot, gap_slot;
    logic wr_fire, rd_fire;

    wrs_slot_seq #(.GROUP_LEN(GROUP_LEN), .TA_W(TA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ta_cycles(ta_cycles),
        .wr_slot(wr_slot), .rd_slot(rd_slot), .gap_slot(gap_slot)
    );

    // Open the handshake of the side that owns this slot.
    always_comb begin
        wr_ready = wr_slot;
        rd_ready = rd_slot;
        wr_fire  = wr_valid && wr_slot;
        rd_fire  = rd_valid && rd_slot;
    end

    wrs_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .cmd_valid(mem_cmd_valid), .cmd_write(mem_cmd_write),
        .cmd_addr(mem_cmd_addr), .cmd_data(mem_cmd_data)
    );

    wrs_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .data_slot(wr_slot || rd_slot), .gap_slot(gap_slot),
        .cnt_writes(cnt_writes), .cnt_reads(cnt_reads),
        .cnt_idle(cnt_idle_slots), .cnt_gap(cnt_turnaround)
    );

    AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ready && rd_ready)); // R4
    AST_WR_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (mem_cmd_valid && mem_cmd_write
                                    && mem_cmd_addr == $past(wr_addr))); // R5
    AST_RD_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> (mem_cmd_valid && !mem_cmd_write
                                    && mem_cmd_addr == $past(rd_addr))); // R5
    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_valid && wr_ready) && !(rd_valid && rd_ready)) |=> !mem_cmd_valid); // R6
endmodule

// File: tb/wr_rd_slot_sched_bench.sv
module wr_rd_slot_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 512;
    localparam int CW = 16;
    localparam int NVEC = 6;
    // Vector packing: {ta[1:0], write-valid mask[3:0], read-valid mask[3:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd0, 4'hF, 4'hF},
        {2'd1, 4'hF, 4'h0},
        {2'd2, 4'h5, 4'hA},
        {2'd3, 4'h0, 4'hF},
        {2'd0, 4'h9, 4'h6},
        {2'd1, 4'h0, 4'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ta_cycles = 2'd0;
    logic          wr_valid = 1'b0, rd_valid = 1'b0;
    logic          wr_ready, rd_ready;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          mem_cmd_valid, mem_cmd_write;
    logic [AW-1:0] mem_cmd_addr;
    logic [DW-1:0] mem_cmd_data;
    logic [CW-1:0] cnt_writes, cnt_reads, cnt_idle_slots, cnt_turnaround;

    int n_chk = 0, n_fail = 0;
    int e_wr = 0, e_rd = 0, e_idle = 0, e_ta = 0;
    bit done = 1'b0;

    wr_rd_slot_sched u_wr_rd_slot_sched (
        .clk(clk), .rst_n(rst_n), .ta_cycles(ta_cycles),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .mem_cmd_valid(mem_cmd_valid), .mem_cmd_write(mem_cmd_write),
        .mem_cmd_addr(mem_cmd_addr), .mem_cmd_data(mem_cmd_data),
        .cnt_writes(cnt_writes), .cnt_reads(cnt_reads),
        .cnt_idle_slots(cnt_idle_slots), .cnt_turnaround(cnt_turnaround)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One cycle, entered just after a falling edge. kind: 0 write slot,
    // 1 read slot, 2 gap. Checks readies, then the command after the edge.
    task automatic step(input int kind, input bit v, input logic [AW-1:0] a);
        logic [DW-1:0] d;
        d = {(DW/AW){a ^ 16'h5A5A}};
        wr_valid = (kind == 0) && v;
        rd_valid = (kind == 1) && v;
        wr_addr = a; rd_addr = a; wr_data = d;
        #1;
        chk(wr_ready == (kind == 0), "R2 wr_ready", 64'(wr_ready), 64'(kind == 0));
        chk(rd_ready == (kind == 1), "R4 rd_ready", 64'(rd_ready), 64'(kind == 1));
        @(posedge clk); #1;
        if (kind == 2) begin
            e_ta++;
            chk(!mem_cmd_valid, "R3 gap cmd", 64'(mem_cmd_valid), 64'd0);
        end else if (!v) begin
            e_idle++;
            chk(!mem_cmd_valid, "R6 idle cmd", 64'(mem_cmd_valid), 64'd0);
        end else begin
            if (kind == 0) e_wr++; else e_rd++;
            chk(mem_cmd_valid && mem_cmd_write == (kind == 0) && mem_cmd_addr == a,
                "R5 cmd", {mem_cmd_valid, mem_cmd_write, mem_cmd_addr},
                {1'b1, kind == 0, a});
            chk(mem_cmd_data == ((kind == 0) ? d : '0), "R5 data",
                mem_cmd_data[63:0], (kind == 0) ? d[63:0] : 64'd0);
        end
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;
    endtask

    task automatic chk_counters(input string tag);
        chk(cnt_writes == CW'(e_wr), {"R7 writes ", tag}, 64'(cnt_writes), 64'(e_wr));
        chk(cnt_reads == CW'(e_rd), {"R7 reads ", tag}, 64'(cnt_reads), 64'(e_rd));
        chk(cnt_idle_slots == CW'(e_idle), {"R7 idle ", tag}, 64'(cnt_idle_slots), 64'(e_idle));
        chk(cnt_turnaround == CW'(e_ta), {"R7 gap ", tag}, 64'(cnt_turnaround), 64'(e_ta));
    endtask

    task automatic chk_reset_state(input string tag);
        chk(!mem_cmd_valid && wr_ready && !rd_ready, {"R1 ", tag},
            {mem_cmd_valid, wr_ready, rd_ready}, 64'b010);
        e_wr = 0; e_rd = 0; e_idle = 0; e_ta = 0;
        chk_counters(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk_reset_state("reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: each vector is one whole period.
        for (int i = 0; i < NVEC; i++) begin
            ta_cycles = VEC[i][9:8];
            for (int s = 0; s < 4; s++)
                step(0, VEC[i][4+s], AW'(i*256 + s*2) ^ 16'hA5C3);
            for (int g = 0; g < int'(VEC[i][9:8]); g++) step(2, 1'b0, '0);
            for (int s = 0; s < 4; s++)
                step(1, VEC[i][s], AW'(i*256 + s*2 + 1) ^ 16'h3C69);
            for (int g = 0; g < int'(VEC[i][9:8]); g++) step(2, 1'b0, '0);
            chk_counters("vector");
        end

        // R8: gap length is fixed when the group ends; changing it mid-gap
        // must not shorten it. Then zero gap at the read-to-write change (R3).
        ta_cycles = 2'd3;
        for (int s = 0; s < 4; s++) step(0, 1'b1, AW'(16'h7000 + s));
        ta_cycles = 2'd0;
        for (int g = 0; g < 3; g++) step(2, 1'b0, '0);
        for (int s = 0; s < 4; s++) step(1, 1'b1, AW'(16'h7100 + s));
        step(0, 1'b1, 16'h7200);
        chk_counters("R8");

        // R1: reset in the middle of the read group restarts with writes.
        for (int s = 0; s < 3; s++) step(0, 1'b0, '0);
        step(1, 1'b1, 16'h7300);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk_reset_state("midrun");
        @(negedge clk);
        rst_n = 1'b1;
        ta_cycles = 2'd2;
        for (int s = 0; s < 4; s++) step(0, 1'b1, AW'(16'h7400 + s));
        for (int g = 0; g < 2; g++) step(2, 1'b0, '0);
        step(1, 1'b1, 16'h7500);
        chk_counters("after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule